// File: doc/BRIEF.md
# Vector Bitwise Logic Unit

This unit performs whole-register bitwise logic for a SIMD datapath with wide registers. Each accepted operation takes three full-width operands: the current contents of the destination register and two source registers. Four operations combine only the two sources. Three operations also use the old destination value as a per-bit mask or selector, so that bits can be merged into an existing register without a separate read-modify-write.

The caller presents the decoded operands, a 3-bit operation code and the 15-bit register-index field of the instruction word (word bits [20:6]). It raises `in_valid` for one cycle per operation. One clock later the result appears on `out_data` with `out_valid`, along with the three register indices so that write-back logic knows where the result goes. The unit also keeps a per-register modified mask. When tracking is enabled, each accepted operation marks its destination register in this mask. The mask is cleared by reset or by a clear strobe.

Top module: `vec_logic_unit`

## Requirements
- R1: Operation codes 0, 1, 2 and 3 give ws AND wt, ws OR wt, NOT(ws OR wt) and ws XOR wt respectively, over every bit of the data width.
- R2: Operation code 4 (move where mask set) gives (wd AND NOT wt) OR (ws AND wt).
- R3: Operation code 5 (move where mask clear) gives (wd AND wt) OR (ws AND NOT wt).
- R4: Operation code 6 (bit select) gives (ws AND NOT wd) OR (wt AND wd), with the old destination choosing wt where it is 1.
- R5: A cycle with `in_valid` high and a defined code raises `out_valid` in the next cycle with the result. `out_valid` is low after any cycle without such an input.
- R6: Code 7 is undefined. It produces no `out_valid`, leaves `out_data` and the index outputs unchanged, and does not change the mask.
- R7: `reg_fields` carries instruction bits [20:6]: wd index at [4:0], ws index at [9:5] and wt index at [14:10]. They are returned on `out_wd_idx`, `out_ws_idx` and `out_wt_idx` with the result.
- R8: When an accepted defined operation has `track_en` high, bit wd of `mod_mask` is set in the next cycle and no other bit changes. With `track_en` low, the mask is unchanged.
- R9: `mask_clr` high makes `mod_mask` zero in the next cycle, and this takes priority over a set in the same cycle.
- R10: A synchronous active-high reset makes `out_valid`, `out_data`, the index outputs and `mod_mask` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request strobe |
| op_sel | input | 3 | Operation code |
| reg_fields | input | 15 | Instruction bits [20:6]: wt, ws, wd indices |
| wd_data | input | DATA_W | Old destination register value |
| ws_data | input | DATA_W | First source register value |
| wt_data | input | DATA_W | Second source register value |
| track_en | input | 1 | Write-tracking enable |
| mask_clr | input | 1 | Clears the modified mask |
| out_valid | output | 1 | Result valid |
| out_data | output | DATA_W | Result |
| out_wd_idx | output | 5 | Destination index of the result |
| out_ws_idx | output | 5 | First source index |
| out_wt_idx | output | 5 | Second source index |
| mod_mask | output | NUM_REGS | Modified-register mask |

## Verification
The bench builds the unit with a 4-bit data width split into two 2-bit slices and keeps 32 registers. At this width, every combination of the three operands (4096 triples) can be swept under each of the eight operation codes, the undefined one included. Each result is compared with its bitwise formula. The sweep also walks the destination index over all 32 mask bits, switching tracking on and off and inserting clears, some of them in the same cycle as a set, so that the mask is checked against a model after every operation.

// File: rtl/vlu_pkg.sv
package vlu_pkg;
  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_NOR  = 3'd2,
    OP_XOR  = 3'd3,
    OP_MNZ  = 3'd4,
    OP_MZ   = 3'd5,
    OP_SEL  = 3'd6,
    OP_UNDF = 3'd7
  } vlu_op_e;

  function automatic logic op_defined(input logic [2:0] code);
    return code != OP_UNDF;
  endfunction
endpackage

// File: rtl/vlu_slice.sv
module vlu_slice
  import vlu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] d,
  input  logic [W-1:0] s,
  input  logic [W-1:0] t,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (vlu_op_e'(op))
      OP_AND:  y = s & t;
      OP_OR:   y = s | t;
      OP_NOR:  y = ~(s | t);
      OP_XOR:  y = s ^ t;
      OP_MNZ:  y = (d & ~t) | (s & t);
      OP_MZ:   y = (d & t) | (s & ~t);
      OP_SEL:  y = (s & ~d) | (t & d);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/vlu_mask_track.sv
module vlu_mask_track #(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                set,
  input  logic [IDX_W-1:0]    idx,
  output logic [NUM_REGS-1:0] mask
);
  logic [NUM_REGS-1:0] hit;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      hit[i] = set && (idx == IDX_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) mask <= '0;
    else            mask <= mask | hit;
  end
endmodule

// File: rtl/vec_logic_unit.sv
module vec_logic_unit
  import vlu_pkg::*;
#(
  parameter int DATA_W   = 128,
  parameter int SLICE_W  = 32,
  parameter int NUM_REGS = 32,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int NSLICE  = DATA_W / SLICE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [2:0]          op_sel,
  input  logic [3*IDX_W-1:0]  reg_fields,
  input  logic [DATA_W-1:0]   wd_data,
  input  logic [DATA_W-1:0]   ws_data,
  input  logic [DATA_W-1:0]   wt_data,
  input  logic                track_en,
  input  logic                mask_clr,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_data,
  output logic [IDX_W-1:0]    out_wd_idx,
  output logic [IDX_W-1:0]    out_ws_idx,
  output logic [IDX_W-1:0]    out_wt_idx,
  output logic [NUM_REGS-1:0] mod_mask
);
  logic [DATA_W-1:0] comb_res;
  logic              accept;
  logic [IDX_W-1:0]  wd_idx, ws_idx, wt_idx;

  assign wd_idx = reg_fields[IDX_W-1:0];
  assign ws_idx = reg_fields[2*IDX_W-1:IDX_W];
  assign wt_idx = reg_fields[3*IDX_W-1:2*IDX_W];
  assign accept = in_valid && op_defined(op_sel);

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    vlu_slice #(.W(SLICE_W)) u_slice (
      .op (op_sel),
      .d  (wd_data[g*SLICE_W +: SLICE_W]),
      .s  (ws_data[g*SLICE_W +: SLICE_W]),
      .t  (wt_data[g*SLICE_W +: SLICE_W]),
      .y  (comb_res[g*SLICE_W +: SLICE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_wd_idx <= '0;
      out_ws_idx <= '0;
      out_wt_idx <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_data   <= comb_res;
        out_wd_idx <= wd_idx;
        out_ws_idx <= ws_idx;
        out_wt_idx <= wt_idx;
      end
    end
  end

  vlu_mask_track #(.NUM_REGS(NUM_REGS)) u_mask (
    .clk  (clk),
    .rst  (rst),
    .clr  (mask_clr),
    .set  (accept && track_en),
    .idx  (wd_idx),
    .mask (mod_mask)
  );
endmodule

// File: rtl/vlu_checker.sv
module vlu_checker #(
  parameter int DATA_W   = 128,
  parameter int NUM_REGS = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [2:0]          op_sel,
  input logic [DATA_W-1:0]   ws_data,
  input logic [DATA_W-1:0]   wt_data,
  input logic                track_en,
  input logic                mask_clr,
  input logic                out_valid,
  input logic [DATA_W-1:0]   out_data,
  input logic [IDX_W-1:0]    out_wd_idx,
  input logic [NUM_REGS-1:0] mod_mask
);
  a_r5_valid_next: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel != 3'd7) |=> out_valid);

  a_r5_idle_low: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r6_undef_hold: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd7) |=> (!out_valid && $stable(out_data) && $stable(out_wd_idx)));

  a_r6_undef_mask: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd7 && !mask_clr) |=> $stable(mod_mask));

  a_r1_xor: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd3) |=> out_data == ($past(ws_data) ^ $past(wt_data)));

  a_r8_no_track: assert property (@(posedge clk) disable iff (rst)
    (!mask_clr && !(in_valid && track_en)) |=> $stable(mod_mask));

  a_r8_monotonic: assert property (@(posedge clk) disable iff (rst)
    !mask_clr |=> ((mod_mask & $past(mod_mask)) == $past(mod_mask)));

  a_r8_one_bit: assert property (@(posedge clk) disable iff (rst)
    !mask_clr |=> $countones(mod_mask ^ $past(mod_mask)) <= 1);

  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    mask_clr |=> mod_mask == '0);

  a_r10_reset: assert property (@(posedge clk)
    rst |=> (!out_valid && mod_mask == '0));
endmodule

bind vec_logic_unit vlu_checker #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_vlu_checker (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .op_sel     (op_sel),
  .ws_data    (ws_data),
  .wt_data    (wt_data),
  .track_en   (track_en),
  .mask_clr   (mask_clr),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .out_wd_idx (out_wd_idx),
  .mod_mask   (mod_mask)
);

// File: tb/test_vec_logic_unit.sv
`timescale 1ns/1ps
module test_vec_logic_unit;
  localparam int DW = 4;
  localparam int NR = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [2:0]    op_sel;
  logic [14:0]   reg_fields;
  logic [DW-1:0] wd_data, ws_data, wt_data;
  logic          track_en, mask_clr;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic [4:0]    out_wd_idx, out_ws_idx, out_wt_idx;
  logic [NR-1:0] mod_mask;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  vec_logic_unit #(.DATA_W(DW), .SLICE_W(2), .NUM_REGS(NR)) i_vec_logic_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .reg_fields(reg_fields), .wd_data(wd_data), .ws_data(ws_data),
    .wt_data(wt_data), .track_en(track_en), .mask_clr(mask_clr),
    .out_valid(out_valid), .out_data(out_data), .out_wd_idx(out_wd_idx),
    .out_ws_idx(out_ws_idx), .out_wt_idx(out_wt_idx), .mod_mask(mod_mask)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model(input int op, input logic [DW-1:0] d,
                                           input logic [DW-1:0] s, input logic [DW-1:0] t);
    case (op)
      0: return s & t;
      1: return s | t;
      2: return ~(s | t);
      3: return s ^ t;
      4: return (d & ~t) | (s & t);
      5: return (d & t) | (s & ~t);
      6: return (s & ~d) | (t & d);
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(input int op);
    case (op)
      0, 1, 2, 3: return "R1";
      4: return "R2";
      5: return "R3";
      6: return "R4";
      default: return "R6";
    endcase
  endfunction

  logic [DW-1:0] exp_data = '0;
  logic [4:0]    exp_wd = '0, exp_ws = '0, exp_wt = '0;
  logic [NR-1:0] exp_mask = '0;

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; op_sel = '0; reg_fields = '0;
    wd_data = '0; ws_data = '0; wt_data = '0; track_en = 1'b0; mask_clr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 out_valid", 32'(out_valid), 0);
    chk("R10 out_data", 32'(out_data), 0);
    chk("R10 out_wd_idx", 32'(out_wd_idx), 0);
    chk("R10 mod_mask", mod_mask, 0);
    @(negedge clk);
    rst = 1'b0;

    for (int op = 0; op < 8; op++) begin
      for (int v = 0; v < 4096; v++) begin
        logic [DW-1:0] d, s, t;
        logic [4:0] iw, is, it;
        logic te, cl;
        d = v[3:0]; s = v[7:4]; t = v[11:8];
        iw = 5'((v * 7 + op) % 32);
        is = 5'(v % 32);
        it = 5'((v / 32) % 32);
        te = v[2] ^ v[9] ^ op[0];
        cl = (v % 211) == 5;
        @(negedge clk);
        in_valid = 1'b1; op_sel = 3'(op); reg_fields = {it, is, iw};
        wd_data = d; ws_data = s; wt_data = t; track_en = te; mask_clr = cl;
        if (op != 7) begin
          exp_data = model(op, d, s, t);
          exp_wd = iw; exp_ws = is; exp_wt = it;
        end
        if (cl) exp_mask = '0;
        else if (op != 7 && te) exp_mask[iw] = 1'b1;
        @(posedge clk);
        #1;
        chk("R5 out_valid", 32'(out_valid), (op != 7) ? 1 : 0);
        chk(req_of(op), 32'(out_data), 32'(exp_data));
        chk("R7 out_wd_idx", 32'(out_wd_idx), 32'(exp_wd));
        chk("R7 out_ws_idx", 32'(out_ws_idx), 32'(exp_ws));
        chk("R7 out_wt_idx", 32'(out_wt_idx), 32'(exp_wt));
        chk(cl ? "R9 mask clear" : "R8 mask track", mod_mask, exp_mask);
        if (v % 64 == 63) begin
          @(negedge clk);
          in_valid = 1'b0; mask_clr = 1'b0; track_en = 1'b1;
          @(posedge clk);
          #1;
          chk("R5 idle out_valid", 32'(out_valid), 0);
          chk("R8 idle mask", mod_mask, exp_mask);
        end
      end
    end

    @(negedge clk);
    in_valid = 1'b0; mask_clr = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R10 late out_valid", 32'(out_valid), 0);
    chk("R10 late out_data", 32'(out_data), 0);
    chk("R10 late mod_mask", mod_mask, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule